// File: doc/BRIEF.md
# I2C Target Controller with Host Action Codes

This block is a target (slave) on an I2C bus. It compares every address byte a controller sends against a 7-bit own address held in a host register. When the address matches, it acknowledges it. In a write transfer, each received byte is handed to the host through a data register. In a read transfer, the host supplies each outgoing byte through that same register.

An action code tells the host what the block needs: read the data register, write it, or nothing. While an action is pending, the block holds SCL low, so the bus waits for the host instead of losing data. A separate code flags the first byte after the address, so the host can treat it as a sub-address.

Three interrupt sources are kept apart: a byte event, a start condition and a stop condition. Each source has an enable bit, a raw status bit, a masked status bit and a write-one-to-clear bit. The SCL and SDA pins are open-drain: an `_oe_o` output at 1 pulls its line low.

Top module: `i2cs_top`

## Requirements
- R1: The 7-bit own address is compared with bits 7:1 of each address byte that follows a start condition. Bit 0 selects the direction (1 = read). A match is acknowledged by pulling SDA low in the ninth clock. A mismatch is not acknowledged, and the block leaves the bus alone until the next start condition.
- R2: The action register (offset 3) reads 0 when nothing is pending, 0x1 when a received byte waits to be read, and 0x2 when a byte must be supplied. It reads 0x5 (0x1 plus bit 2) when the waiting byte is the first one after the address.
- R3: A received byte is read from the data register (offset 2). A read of that register clears the receive request. The byte is then acknowledged.
- R4: In a read transfer, a transmit request is raised after the address is acknowledged and after every byte the controller acknowledges. A write of the data register clears the request, and that byte is shifted out MSB first.
- R5: SCL is held low for as long as the action code is nonzero. It is released in the cycle the host services the request.
- R6: When the controller does not acknowledge a byte it has read, the block releases SDA and raises no further transmit request.
- R7: A start or stop condition returns the byte logic to its address or idle state from any state, so a repeated start begins a new address phase.
- R8: Interrupt source bits are data = bit 0, start = bit 1 and stop = bit 2. Raw status (offset 5) latches every event. Masked status (offset 6) is raw AND enable (offset 4). `irq_o` is the OR of the masked bits.
- R9: Writing a mask to the clear register (offset 7) clears the matching raw bits.
- R10: With the enable bit (offset 0, bit 0) at 0, the block acknowledges nothing, never holds SCL low and records no interrupt events.
- R11: The own address is written and read back at offset 1. After reset, all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_i | input | 3 | Host register offset |
| reg_we_i | input | 1 | Host write strobe |
| reg_re_i | input | 1 | Host read strobe (side effect on data register) |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for reg_addr_i |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a bus that is held while the host has not yet answered. The bench models SCL and SDA as wired-AND lines. Its bus driver waits for SCL to actually rise before it continues. A host process, running in parallel, polls the action code, deliberately delays its service, and checks during that delay that SCL stays low. The repeated start in the middle of a transfer and the controller's NACK on the last byte read are produced by the same driver, so the return to the address phase and the release of SDA are both observed on the pins.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int NUM_IRQ = 3;

  localparam int IRQ_DATA  = 0;
  localparam int IRQ_START = 1;
  localparam int IRQ_STOP  = 2;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_OWN  = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_ACT  = 3'd3;
  localparam logic [2:0] REG_IEN  = 3'd4;
  localparam logic [2:0] REG_RAW  = 3'd5;
  localparam logic [2:0] REG_MIS  = 3'd6;
  localparam logic [2:0] REG_CLR  = 3'd7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RX_WAIT,
    ST_RX_ACK, ST_TX_WAIT, ST_TX, ST_TX_ACK
  } st_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edge while SCL stays high marks a bus condition
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_byte_fsm.sv
module i2cs_byte_fsm
  import i2cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [2:0]        act_o,
  output logic              data_ev_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  st_e               state_q;
  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q, first_q, nack_q;
  logic              shifting;

  assign shifting = (state_q == ST_ADDR || state_q == ST_RX) && scl_rise_i && cnt_q != CNT_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sr_q      <= '0;
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      rx_byte_o <= '0;
      sda_oe_o  <= 1'b0;
      data_ev_o <= 1'b0;
    end else begin
      data_ev_o <= 1'b0;
      if (!en_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (shifting) begin
        sr_q  <= {sr_q[BYTE_W-2:0], sda_i};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_fall_i && cnt_q == CNT_FULL) begin
            if (sr_q[BYTE_W-1:1] == own_addr_i) begin
              sda_oe_o <= 1'b1;
              rw_q     <= sr_q[0];
              state_q  <= ST_AACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
          ST_AACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            if (rw_q) begin
              state_q   <= ST_TX_WAIT;
              data_ev_o <= 1'b1;
            end else begin
              first_q <= 1'b1;
              state_q <= ST_RX;
            end
          end
          ST_RX: if (scl_fall_i && cnt_q == CNT_FULL) begin
            rx_byte_o <= sr_q;
            state_q   <= ST_RX_WAIT;
            data_ev_o <= 1'b1;
          end
          ST_RX_WAIT: if (host_rd_i) begin
            sda_oe_o <= 1'b1;
            first_q  <= 1'b0;
            state_q  <= ST_RX_ACK;
          end
          ST_RX_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_RX;
          end
          ST_TX_WAIT: if (host_wr_i) begin
            sr_q     <= host_wdata_i;
            sda_oe_o <= ~host_wdata_i[BYTE_W-1];
            cnt_q    <= '0;
            state_q  <= ST_TX;
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              sr_q     <= {sr_q[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~sr_q[BYTE_W-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) nack_q <= sda_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                state_q   <= ST_TX_WAIT;
                data_ev_o <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // action code: bit0 receive pending, bit1 transmit pending, bit2 first byte
  assign act_o    = {first_q && state_q == ST_RX_WAIT, state_q == ST_TX_WAIT, state_q == ST_RX_WAIT};
  assign scl_oe_o = state_q == ST_RX_WAIT || state_q == ST_TX_WAIT;
endmodule

// File: rtl/i2cs_irq.sv
module i2cs_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] ien_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mis_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      raw_o[k] <= 1'b0;
      else if (ev_i[k])                 raw_o[k] <= 1'b1;
      else if (clr_we_i && clr_mask_i[k]) raw_o[k] <= 1'b0;
    end
    assign mis_o[k] = raw_o[k] & ien_i[k];
  end
  assign irq_o = |mis_o;
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic               en_q;
  logic [ADDR_W-1:0]  own_q;
  logic [NUM_IRQ-1:0] ien_q, irq_ev, irq_raw, irq_mis;
  logic [BYTE_W-1:0]  rx_byte;
  logic [2:0]         act_code;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, data_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      own_q <= '0;
      ien_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        REG_CTRL: en_q  <= reg_wdata_i[0];
        REG_OWN:  own_q <= reg_wdata_i[ADDR_W-1:0];
        REG_IEN:  ien_q <= reg_wdata_i[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2cs_byte_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(en_q), .own_addr_i(own_q), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .host_rd_i(reg_re_i && reg_addr_i == REG_DATA),
    .host_wr_i(reg_we_i && reg_addr_i == REG_DATA),
    .host_wdata_i(reg_wdata_i), .rx_byte_o(rx_byte), .act_o(act_code),
    .data_ev_o(data_ev), .sda_oe_o, .scl_oe_o
  );

  always_comb begin
    irq_ev            = '0;
    irq_ev[IRQ_DATA]  = data_ev;
    irq_ev[IRQ_START] = start_det & en_q;
    irq_ev[IRQ_STOP]  = stop_det & en_q;
  end

  i2cs_irq #(.N(NUM_IRQ)) u_irq (
    .clk_i, .rst_ni, .ev_i(irq_ev), .ien_i(ien_q),
    .clr_we_i(reg_we_i && reg_addr_i == REG_CLR),
    .clr_mask_i(reg_wdata_i[NUM_IRQ-1:0]),
    .raw_o(irq_raw), .mis_o(irq_mis), .irq_o
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = BYTE_W'(en_q);
      REG_OWN:  reg_rdata_o = BYTE_W'(own_q);
      REG_DATA: reg_rdata_o = rx_byte;
      REG_ACT:  reg_rdata_o = BYTE_W'(act_code);
      REG_IEN:  reg_rdata_o = BYTE_W'(ien_q);
      REG_RAW:  reg_rdata_o = BYTE_W'(irq_raw);
      REG_MIS:  reg_rdata_o = BYTE_W'(irq_mis);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_oe_o,
  input logic               sda_oe_o,
  input logic               en_q,
  input logic [2:0]         act_code,
  input logic [NUM_IRQ-1:0] irq_ev,
  input logic [NUM_IRQ-1:0] irq_raw,
  input logic [2:0]         reg_addr_i,
  input logic               reg_we_i,
  input logic [BYTE_W-1:0]  reg_wdata_i
);
  a_r2_first_only_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_code[2] |-> act_code[0]);
  a_r2_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_code[0] && act_code[1]));
  a_r5_stretch_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> act_code != 3'd0);
  a_r4_tx_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_code == 3'd2 && reg_we_i && reg_addr_i == REG_DATA) |=> act_code == 3'd0);
  a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !$past(en_q)) |-> (!scl_oe_o && !sda_oe_o));
  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CLR && reg_wdata_i[NUM_IRQ-1:0] == '1 && irq_ev == '0)
    |=> irq_raw == '0);
endmodule

bind i2cs_top i2cs_chk i_chk (
  .clk_i, .rst_ni, .scl_oe_o, .sda_oe_o, .en_q, .act_code,
  .irq_ev, .irq_raw, .reg_addr_i, .reg_we_i, .reg_wdata_i
);

// File: tb/test_i2cs_top.sv
module test_i2cs_top;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line, scl_oe, sda_oe, irq;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  int total = 0, bad = 0;
  bit m_done = 1'b0, finished = 1'b0;
  logic [7:0] act_q[$], rx_q[$], tx_q[$];

  always #2 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2cs_top i_i2cs_top (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_addr_i(reg_addr),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // ---- bus driver ----
  task automatic scl_pulse(output logic s);
    wait_cyc(Q);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(Q);
    s = sda_line;
    m_scl_low = 1'b1;
    wait_cyc(Q);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0;
    wait_cyc(Q);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(Q);
    m_sda_low = 1'b1;
    wait_cyc(Q);
    m_scl_low = 1'b1;
    wait_cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1;
    wait_cyc(Q);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(Q);
    m_sda_low = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i];
      scl_pulse(s);
    end
    m_sda_low = 1'b0;
    scl_pulse(ack);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    logic s;
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      scl_pulse(s);
      b[i] = s;
    end
    m_sda_low = ~nack;
    scl_pulse(s);
    m_sda_low = 1'b0;
  endtask

  // ---- host side: scoreboard monitor ----
  task automatic host_loop();
    logic [7:0] a, d, e;
    while (!m_done) begin
      @(negedge clk);
      rd(3'd3, a);
      if (a != 8'h00) begin
        wait_cyc(24);
        chk(scl_line == 1'b0, "R5 scl held while pending", scl_line, 0);
        e = (act_q.size() != 0) ? act_q.pop_front() : 8'hEE;
        chk(a == e, "R2 action code", a, e);
        if (a[0]) begin
          rd(3'd2, d);
          e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hEE;
          chk(d == e, "R3 received byte", d, e);
          reg_re = 1'b1;
          @(negedge clk);
          reg_re = 1'b0;
          rd(3'd3, d);
          chk(d == 8'h00, "R3 read clears request", d, 0);
        end else begin
          e = (tx_q.size() != 0) ? tx_q.pop_front() : 8'h00;
          reg_addr = 3'd2; reg_wdata = e; reg_we = 1'b1;
          @(negedge clk);
          reg_we = 1'b0;
          rd(3'd3, d);
          chk(d == 8'h00, "R4 write clears request", d, 0);
          chk(scl_oe == 1'b0, "R5 scl released on service", scl_oe, 0);
        end
      end
    end
  endtask

  logic [7:0] v;
  logic ack;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R11 reset state
    rd(3'd3, v); chk(v == 8'h00, "R11 reset action", v, 0);
    rd(3'd5, v); chk(v == 8'h00, "R11 reset raw", v, 0);
    rd(3'd1, v); chk(v == 8'h00, "R11 reset own addr", v, 0);
    chk({scl_oe, sda_oe, irq} == 3'b000, "R11 reset outputs", {scl_oe, sda_oe, irq}, 0);

    wr(3'd1, {1'b0, OWN});
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h02);
    rd(3'd1, v); chk(v == {1'b0, OWN}, "R11 own addr readback", v, OWN);

    // write transfer: first byte flagged
    act_q = '{8'h05, 8'h01}; rx_q = '{8'hA5, 8'h3C};
    m_done = 1'b0;
    fork
      begin
        bus_start();
        put_byte({OWN, 1'b0}, ack); chk(ack == 1'b0, "R1 matching address acked", ack, 0);
        put_byte(8'hA5, ack);       chk(ack == 1'b0, "R3 byte acked", ack, 0);
        put_byte(8'h3C, ack);       chk(ack == 1'b0, "R3 byte acked", ack, 0);
        bus_stop();
        m_done = 1'b1;
      end
      host_loop();
    join
    chk(act_q.size() == 0, "R2 all actions seen", act_q.size(), 0);
    rd(3'd5, v); chk(v == 8'h07, "R8 raw all sources", v, 7);
    rd(3'd6, v); chk(v == 8'h02, "R8 masked start only", v, 2);
    chk(irq == 1'b1, "R8 irq from masked start", irq, 1);
    wr(3'd7, 8'h02);
    rd(3'd5, v); chk(v == 8'h05, "R9 clear start bit", v, 5);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    wr(3'd7, 8'h07);
    rd(3'd5, v); chk(v == 8'h00, "R9 clear all", v, 0);

    // foreign address: ignored
    m_done = 1'b0;
    fork
      begin
        bus_start();
        put_byte(8'h44, ack); chk(ack == 1'b1, "R1 foreign address not acked", ack, 1);
        put_byte(8'h00, ack); chk(ack == 1'b1, "R1 later byte ignored", ack, 1);
        chk(scl_oe == 1'b0, "R1 no stretch when not addressed", scl_oe, 0);
        bus_stop();
        m_done = 1'b1;
      end
      host_loop();
    join
    rd(3'd5, v); chk(v == 8'h06, "R8 no data event when not addressed", v, 6);
    wr(3'd7, 8'h07);

    // read transfer, controller NACKs last byte
    act_q = '{8'h02, 8'h02}; tx_q = '{8'h96, 8'h5B};
    m_done = 1'b0;
    fork
      begin
        bus_start();
        put_byte({OWN, 1'b1}, ack); chk(ack == 1'b0, "R1 read address acked", ack, 0);
        get_byte(1'b0, v); chk(v == 8'h96, "R4 first byte out", v, 8'h96);
        get_byte(1'b1, v); chk(v == 8'h5B, "R4 second byte out", v, 8'h5B);
        wait_cyc(20);
        chk(sda_oe == 1'b0, "R6 sda released after nack", sda_oe, 0);
        chk(scl_oe == 1'b0, "R6 no request after nack", scl_oe, 0);
        bus_stop();
        m_done = 1'b1;
      end
      host_loop();
    join
    chk(act_q.size() == 0, "R4 all tx requests seen", act_q.size(), 0);
    wr(3'd7, 8'h07);

    // repeated start switches direction
    act_q = '{8'h05, 8'h02}; rx_q = '{8'h11}; tx_q = '{8'hC3};
    m_done = 1'b0;
    fork
      begin
        bus_start();
        put_byte({OWN, 1'b0}, ack);
        put_byte(8'h11, ack);
        bus_start();
        put_byte({OWN, 1'b1}, ack); chk(ack == 1'b0, "R7 address after repeated start", ack, 0);
        get_byte(1'b1, v); chk(v == 8'hC3, "R7 read after repeated start", v, 8'hC3);
        bus_stop();
        m_done = 1'b1;
      end
      host_loop();
    join
    chk(act_q.size() == 0, "R7 all actions seen", act_q.size(), 0);

    // disabled
    wr(3'd7, 8'h07);
    wr(3'd0, 8'h00);
    bus_start();
    put_byte({OWN, 1'b0}, ack); chk(ack == 1'b1, "R10 no ack when disabled", ack, 1);
    chk(scl_oe == 1'b0, "R10 no stretch when disabled", scl_oe, 0);
    bus_stop();
    rd(3'd5, v); chk(v == 8'h00, "R10 no events when disabled", v, 0);
    rd(3'd3, v); chk(v == 8'h00, "R10 no action when disabled", v, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule